// File: doc/BRIEF.md
# Reset Sequencer With Cause Flags

This block produces the internal reset of a small microcontroller and records why each reset happened. It takes cause events from blocks outside it: a low-voltage detect, a watchdog time-out, a watchdog configuration error, and an invalid setting of the voltage-threshold configuration byte. It also senses the low-power state (sleep or idle) and which internal oscillator is clocking the core. For each cause it holds the internal reset for a number of cycles. That length is the power-on delay plus the oscillator start-up delay for most causes. A watchdog time-out in a low-power state uses only the start-up delay, and that case also emits a strobe that clears the program counter and stack pointer.

The cause flags are sticky. Hardware only ever sets them, and software clears them by writing 0 to the control/status register. The same register holds a system-clock-in-idle enable bit. The watchdog time-out indication is a separate status output. A clear-watchdog strobe or a power-on clears it.

Top module: `rstseq_top`

## Requirements
- R1: While `por_n` is low, `rst_int` is 1, `to_flag` is 0, and control/status bits 7, 1 and 0 read 0. After `por_n` rises, `rst_int` stays 1 for POR_DLY+SST_FAST cycles. Bit 2 is not changed by power-on.
- R2: With `reg_rd` high, `reg_rdata` returns {bit7 clock-in-idle enable, bits 6:3 zero, bit2 low-voltage flag, bit1 invalid-threshold flag, bit0 watchdog-configuration flag}. With `reg_rd` low, it returns 0.
- R3: An `lvd_evt` pulse sets bit 2. Starting at the next cycle, it holds `rst_int` high for POR_DLY plus the start-up delay.
- R4: A `vth_cfg` value outside the four parameter codes (default 0x55, 0x33, 0x99, 0xAA) sets bit 1 and starts a long reset at the next clock edge. It triggers once each time the byte enters an invalid value. It does not trigger again while the value stays invalid.
- R5: A `wdt_cfg_err` pulse sets bit 0 and starts a long reset.
- R6: A `wdt_evt` with `lowpwr` low sets `to_flag`, starts a long reset and gives no `pcsp_clr`.
- R7: A `wdt_evt` with `lowpwr` high sets `to_flag` and holds `rst_int` for the start-up delay only. It pulses `pcsp_clr` for exactly the first reset cycle and leaves the register bits unchanged.
- R8: The start-up delay is SST_FAST cycles when `clk_sel` is 0 (fast oscillator) and SST_SLOW cycles when `clk_sel` is 1 (slow oscillator).
- R9: A new cause that arrives during a reset reloads the full delay for that cause, and the flags of all causes stay set.
- R10: A write sets bit 7 to the written value. Writing 0 to bit 2, 1 or 0 clears that flag, and writing 1 leaves it unchanged. Bits 6:3 ignore writes. A hardware set in the same cycle as a clearing write leaves the flag set.
- R11: `wdt_clr` clears `to_flag`. A watchdog event in the same cycle leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| lvd_evt | input | 1 | Low-voltage detect event |
| wdt_evt | input | 1 | Watchdog time-out event |
| wdt_cfg_err | input | 1 | Watchdog configuration error event |
| wdt_clr | input | 1 | Software clear-watchdog strobe |
| lowpwr | input | 1 | Core is in sleep or idle |
| clk_sel | input | 1 | 0 fast oscillator, 1 slow oscillator |
| vth_cfg | input | 8 | Voltage-threshold configuration byte |
| reg_rd | input | 1 | Register read enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| rst_int | output | 1 | Internal reset, active high |
| pcsp_clr | output | 1 | Program counter and stack pointer clear strobe |
| reg_rdata | output | 8 | Control/status read data |
| to_flag | output | 1 | Watchdog time-out status |

## Verification
The bench builds the block with POR_DLY=20, SST_FAST=16 and SST_SLOW=2. With these values every long reset takes 22 to 36 cycles, so each reset length can be counted exactly. This makes it affordable to sweep every cause against both oscillator selections and both power states. It also makes it affordable to sweep all 256 threshold-byte values, each compared with a validity rule held in the bench. The short delays also let the bench check reload during a running reset, and the cases where a hardware set and a software clear happen in the same cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    localparam int CSR_W    = 8;
    localparam int B_FSYS   = 7;
    localparam int B_LVRF   = 2;
    localparam int B_LRF    = 1;
    localparam int B_WRF    = 0;
    localparam int CFG_W    = 8;

    typedef struct packed {
        logic fsys;
        logic lrf;
        logic wrf;
        logic to;
    } flags_t;
endpackage

// File: rtl/rstseq_vth_check.sv
module rstseq_vth_check
    import rstseq_pkg::*;
#(
    parameter int                   N_CODES   = 4,
    parameter logic [N_CODES*8-1:0] VTH_CODES = 32'hAA99_3355
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [CFG_W-1:0] vth_cfg,
    output logic             bad_trig
);
    logic [N_CODES-1:0] hit;
    logic bad_d, bad_q;

    for (genvar i = 0; i < N_CODES; i++) begin : g_code
        assign hit[i] = (vth_cfg == VTH_CODES[i*8 +: 8]);
    end

    always_comb begin
        bad_d    = ~|hit;
        bad_trig = bad_d & ~bad_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) bad_q <= 1'b0;
        else        bad_q <= bad_d;
    end

    // R4: a trigger is followed by the remembered invalid state
    a_r4_once: assert property (@(posedge clk) disable iff (!por_n)
        bad_trig |=> bad_q);
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
    parameter int POR_DLY  = 66800,
    parameter int SST_FAST = 16,
    parameter int SST_SLOW = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic clk_sel,
    input  logic load_long,
    input  logic load_short,
    output logic rst_int,
    output logic pcsp_clr
);
    localparam int LONG_F = POR_DLY + SST_FAST;
    localparam int LONG_S = POR_DLY + SST_SLOW;
    localparam int MAXL   = (LONG_F > LONG_S) ? LONG_F : LONG_S;
    localparam int CW     = $clog2(MAXL + 1);
    localparam logic [CW-1:0] L_F = CW'(LONG_F);
    localparam logic [CW-1:0] L_S = CW'(LONG_S);
    localparam logic [CW-1:0] S_F = CW'(SST_FAST);
    localparam logic [CW-1:0] S_S = CW'(SST_SLOW);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pcsp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pcsp = 1'b0;
        if (load_long) begin
            st_d.cnt = clk_sel ? L_S : L_F;
        end else if (load_short) begin
            st_d.cnt  = clk_sel ? S_S : S_F;
            st_d.pcsp = 1'b1;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.cnt  <= L_F;
            st_q.pcsp <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_int  = (st_q.cnt != '0);
    assign pcsp_clr = st_q.pcsp;

    // R8: an idle counter only counts down by one
    a_r8_countdown: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.cnt != '0 && !load_long && !load_short)
        |=> (st_q.cnt == $past(st_q.cnt) - CW'(1)));
    // R9: a long cause always reloads the full delay
    a_r9_reload: assert property (@(posedge clk) disable iff (!por_n)
        (load_long && !clk_sel) |=> (st_q.cnt == L_F));
    // R7: the clear strobe only appears inside a reset
    a_r7_pcsp_in_rst: assert property (@(posedge clk) disable iff (!por_n)
        pcsp_clr |-> rst_int);
endmodule

// File: rtl/rstseq_flags.sv
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             reg_wr,
    input  logic [CSR_W-1:0] reg_wdata,
    input  logic             set_lvr,
    input  logic             set_lrf,
    input  logic             set_wrf,
    input  logic             set_to,
    input  logic             wdt_clr,
    output logic [CSR_W-1:0] csr,
    output logic             to_flag
);
    flags_t fl_d, fl_q;
    logic   lvrf_d, lvrf_q;

    always_comb begin
        fl_d   = fl_q;
        lvrf_d = lvrf_q;
        if (reg_wr) begin
            fl_d.fsys = reg_wdata[B_FSYS];
            fl_d.lrf  = fl_q.lrf & reg_wdata[B_LRF];
            fl_d.wrf  = fl_q.wrf & reg_wdata[B_WRF];
            lvrf_d    = lvrf_q & reg_wdata[B_LVRF];
        end
        if (wdt_clr) fl_d.to  = 1'b0;
        if (set_lvr) lvrf_d   = 1'b1;
        if (set_lrf) fl_d.lrf = 1'b1;
        if (set_wrf) fl_d.wrf = 1'b1;
        if (set_to)  fl_d.to  = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    // The low-voltage flag is deliberately left out of power-on reset
    always_ff @(posedge clk) begin
        lvrf_q <= lvrf_d;
    end

    always_comb begin
        csr         = '0;
        csr[B_FSYS] = fl_q.fsys;
        csr[B_LVRF] = lvrf_q;
        csr[B_LRF]  = fl_q.lrf;
        csr[B_WRF]  = fl_q.wrf;
    end
    assign to_flag = fl_q.to;

    // R3: the low-voltage flag is sticky unless software writes 0
    a_r3_lvrf_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (lvrf_q && !(reg_wr && !reg_wdata[B_LVRF])) |=> lvrf_q);
    // R10: a clearing write without a concurrent set clears the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (!por_n)
        (reg_wr && !reg_wdata[B_LRF] && !set_lrf) |=> !fl_q.lrf);
    // R11: a watchdog event always leaves the time-out status set
    a_r11_to_set: assert property (@(posedge clk) disable iff (!por_n)
        set_to |=> to_flag);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int                   POR_DLY   = 66800,
    parameter int                   SST_FAST  = 16,
    parameter int                   SST_SLOW  = 2,
    parameter int                   N_CODES   = 4,
    parameter logic [N_CODES*8-1:0] VTH_CODES = 32'hAA99_3355
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             lvd_evt,
    input  logic             wdt_evt,
    input  logic             wdt_cfg_err,
    input  logic             wdt_clr,
    input  logic             lowpwr,
    input  logic             clk_sel,
    input  logic [CFG_W-1:0] vth_cfg,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [CSR_W-1:0] reg_wdata,
    output logic             rst_int,
    output logic             pcsp_clr,
    output logic [CSR_W-1:0] reg_rdata,
    output logic             to_flag
);
    logic             vth_trig;
    logic             load_long, load_short;
    logic [CSR_W-1:0] csr;

    rstseq_vth_check #(.N_CODES(N_CODES), .VTH_CODES(VTH_CODES)) u_vth (
        .clk(clk), .por_n(por_n), .vth_cfg(vth_cfg), .bad_trig(vth_trig)
    );

    always_comb begin
        load_long  = lvd_evt | wdt_cfg_err | vth_trig | (wdt_evt & ~lowpwr);
        load_short = wdt_evt & lowpwr;
    end

    rstseq_stretch #(.POR_DLY(POR_DLY), .SST_FAST(SST_FAST), .SST_SLOW(SST_SLOW)) u_str (
        .clk(clk), .por_n(por_n), .clk_sel(clk_sel),
        .load_long(load_long), .load_short(load_short),
        .rst_int(rst_int), .pcsp_clr(pcsp_clr)
    );

    rstseq_flags u_flg (
        .clk(clk), .por_n(por_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .set_lvr(lvd_evt), .set_lrf(vth_trig), .set_wrf(wdt_cfg_err),
        .set_to(wdt_evt), .wdt_clr(wdt_clr), .csr(csr), .to_flag(to_flag)
    );

    assign reg_rdata = reg_rd ? csr : '0;

    // R2: unimplemented bits never read as 1
    a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (!por_n)
        reg_rdata[6:3] == 4'b0);
    // R6: a watchdog reset in normal operation gives no clear strobe
    a_r6_no_pcsp: assert property (@(posedge clk) disable iff (!por_n)
        (wdt_evt && !lowpwr) |=> !pcsp_clr);
endmodule

// File: tb/tb_rstseq_top.sv
module tb_rstseq_top;
    localparam int POR = 20;
    localparam int SF  = 16;
    localparam int SS  = 2;

    logic clk = 1'b0;
    logic por_n, lvd_evt, wdt_evt, wdt_cfg_err, wdt_clr, lowpwr, clk_sel;
    logic [7:0] vth_cfg, reg_wdata, reg_rdata;
    logic reg_rd, reg_wr, rst_int, pcsp_clr, to_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rstseq_top #(.POR_DLY(POR), .SST_FAST(SF), .SST_SLOW(SS)) dut (
        .clk(clk), .por_n(por_n), .lvd_evt(lvd_evt), .wdt_evt(wdt_evt),
        .wdt_cfg_err(wdt_cfg_err), .wdt_clr(wdt_clr), .lowpwr(lowpwr),
        .clk_sel(clk_sel), .vth_cfg(vth_cfg), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .rst_int(rst_int), .pcsp_clr(pcsp_clr),
        .reg_rdata(reg_rdata), .to_flag(to_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic bit code_ok(input logic [7:0] v);
        return (v == 8'h55) || (v == 8'h33) || (v == 8'h99) || (v == 8'hAA);
    endfunction

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (rst_int && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // which: 0 low-voltage, 1 watchdog, 2 watchdog config error
    task automatic pulse(input int which, output bit pc);
        case (which)
            0: lvd_evt = 1'b1;
            1: wdt_evt = 1'b1;
            default: wdt_cfg_err = 1'b1;
        endcase
        @(negedge clk);
        lvd_evt = 1'b0; wdt_evt = 1'b0; wdt_cfg_err = 1'b0;
        pc = pcsp_clr;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        bit pc;
        por_n = 1'b0; lvd_evt = 1'b0; wdt_evt = 1'b0; wdt_cfg_err = 1'b0;
        wdt_clr = 1'b0; lowpwr = 1'b0; clk_sel = 1'b0; vth_cfg = 8'h55;
        reg_rd = 1'b1; reg_wr = 1'b0; reg_wdata = 8'h00;

        // R1: power-on state and stretch
        repeat (3) @(negedge clk);
        chk(rst_int == 1'b1, "R1 rst during por", int'(rst_int), 1);
        chk((reg_rdata & 8'h83) == 8'h00, "R1 csr bits 7,1,0", int'(reg_rdata & 8'h83), 0);
        chk(to_flag == 1'b0, "R1 to_flag", int'(to_flag), 0);
        por_n = 1'b1;
        measure(n);
        chk(n == POR + SF, "R1 por length", n, POR + SF);

        // R10: clear everything, then write behaviour
        wr(8'h00);
        chk(reg_rdata == 8'h00, "R10 cleared csr", int'(reg_rdata), 0);
        wr(8'hFF);
        chk(reg_rdata == 8'h80, "R10 write ones", int'(reg_rdata), 8'h80);
        reg_rd = 1'b0;
        #1;
        chk(reg_rdata == 8'h00, "R2 no read gives 0", int'(reg_rdata), 0);
        @(negedge clk);
        reg_rd = 1'b1;
        wr(8'h00);
        chk(reg_rdata == 8'h00, "R10 fsys cleared", int'(reg_rdata), 0);

        // R3 R5 R6 R7 R8: cause x oscillator x power state sweep
        for (int c = 0; c < 3; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 2; p++) begin
                    int exp_len;
                    bit shortr;
                    clk_sel = s[0]; lowpwr = p[0];
                    @(negedge clk);
                    shortr  = (c == 1) && (p == 1);
                    exp_len = (shortr ? 0 : POR) + ((s == 1) ? SS : SF);
                    pulse(c, pc);
                    chk(pc == shortr, "R7 pcsp_clr strobe", int'(pc), int'(shortr));
                    measure(n);
                    chk(n == exp_len, "R8 reset length", n, exp_len);
                    chk(pcsp_clr == 1'b0, "R7 strobe one cycle", int'(pcsp_clr), 0);
                    chk(reg_rdata == ((c == 0) ? 8'h04 : (c == 2) ? 8'h01 : 8'h00),
                        "R3 R5 R7 cause flags", int'(reg_rdata),
                        (c == 0) ? 4 : (c == 2) ? 1 : 0);
                    chk(to_flag == (c == 1), "R6 to_flag set", int'(to_flag), int'(c == 1));
                    lowpwr = 1'b0;
                    wr(8'h00);
                    wdt_clr = 1'b1;
                    @(negedge clk);
                    wdt_clr = 1'b0;
                    chk(to_flag == 1'b0 && reg_rdata == 8'h00, "R11 clear",
                        int'({to_flag, reg_rdata}), 0);
                end
            end
        end
        clk_sel = 1'b0;

        // R9: reload during a running reset, flags accumulate
        pulse(0, pc);
        repeat (10) @(negedge clk);
        pulse(2, pc);
        measure(n);
        chk(n == POR + SF, "R9 reload length", n, POR + SF);
        chk(reg_rdata == 8'h05, "R9 both flags", int'(reg_rdata), 5);
        wr(8'h00);

        // R10: hardware set wins over clearing write
        lvd_evt = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00;
        @(negedge clk);
        lvd_evt = 1'b0; reg_wr = 1'b0;
        chk(reg_rdata[2] == 1'b1, "R10 set wins", int'(reg_rdata[2]), 1);
        measure(n);
        wr(8'h00);

        // R11: watchdog event wins over clear strobe
        wdt_evt = 1'b1; wdt_clr = 1'b1;
        @(negedge clk);
        wdt_evt = 1'b0; wdt_clr = 1'b0;
        chk(to_flag == 1'b1, "R11 set wins", int'(to_flag), 1);
        measure(n);
        wdt_clr = 1'b1;
        @(negedge clk);
        wdt_clr = 1'b0;

        // R4: all threshold-byte values
        for (int v = 0; v < 256; v++) begin
            bit bad;
            bad = !code_ok(8'(v));
            vth_cfg = 8'(v);
            @(negedge clk);
            chk(reg_rdata[1] == bad, "R4 flag for code", int'(reg_rdata[1]), int'(bad));
            chk(rst_int == bad, "R4 reset for code", int'(rst_int), int'(bad));
            if (bad) begin
                measure(n);
                chk(n == POR + SF, "R4 single trigger", n, POR + SF);
            end
            vth_cfg = 8'h55;
            @(negedge clk);
            wr(8'h00);
            chk(reg_rdata == 8'h00, "R4 flag cleared", int'(reg_rdata), 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule